// File: doc/BRIEF.md
# Streaming Pixel Calibration Pipeline

This block corrects a line-scan sensor stream on the fly. Each clock it may accept one raw pixel tagged with its column and spectral band. It looks up a per-pixel calibration entry selected by band and column. It removes the pixel's dark offset, scales the result by a per-pixel flat-field gain, and replaces pixels marked as bad with a median of their same-band neighbours. The pipeline has no stall input and no ready output: every accepted pixel leaves a fixed number of cycles later.

The calibration entries are loaded through a host write port into a staging copy. The staging copy becomes the working copy at the first pixel of each line. A line is therefore always corrected with a single consistent set of coefficients, while the host may write at any time.

A line is a run of contiguous valid cycles. Its first cycle carries the start flag and its last cycle carries the end flag. Every pixel in a line has the same band, the columns rise by one per pixel, and a line holds at least two pixels.

Top module: `calib_pipe`

## Requirements
- R1: Every input pixel appears at the output exactly 4 cycles after the cycle it was presented in, with its start, end, column and band tags unchanged. An output is valid only in those cycles, and the pipeline never holds back a pixel.
- R2: The offset step computes raw minus the entry's offset, and a negative result is clamped to 0.
- R3: The clamped difference is multiplied by the entry's 16-bit gain, which has 8 fractional bits (0x0100 = 1.0). The 16-bit output carries 8 fractional bits, so output = difference × gain.
- R4: A product above 0xFFFF is saturated to 0xFFFF.
- R5: The calibration entry is selected by band and column (index = band × COLS + column), so the same raw value in different bands can be corrected differently.
- R6: A pixel whose entry has its bad-pixel bit set is output as the median of three values: the corrected left neighbour, the corrected right neighbour, and the output at the same column on the previous line of the same band. An unflagged pixel is output as its corrected value.
- R7: At the first pixel of a line, the right neighbour stands in for the missing left one. At the last pixel, the left neighbour stands in for the missing right one.
- R8: While a band has not yet completed a line since reset, the previous-line value is replaced by the left value (after the R7 substitution).
- R9: Host writes go to a staging copy that is taken over only by the first pixel of a line. A write made in any cycle of a line, including its first cycle, does not affect that line. It does affect the next line, even one that follows with no idle cycle.
- R10: After reset the output is not valid, and every entry holds offset 0, gain 1.0 and a clear bad-pixel bit, so a pixel comes out as raw × 256.
- R11: The previous-line value used by R6 is the final output of that pixel, including any replacement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present |
| in_sol | input | 1 | First pixel of a line |
| in_eol | input | 1 | Last pixel of a line |
| in_col | input | 8 | Column index |
| in_band | input | 2 | Spectral band |
| in_pix | input | 8 | Raw pixel value |
| wr_en | input | 1 | Host write strobe |
| wr_col | input | 8 | Column of entry to write |
| wr_band | input | 2 | Band of entry to write |
| wr_bias | input | 8 | Offset value |
| wr_gain | input | 16 | Gain, 8 fractional bits |
| wr_defect | input | 1 | Bad-pixel marker |
| out_valid | output | 1 | Output pixel present |
| out_sol | output | 1 | First pixel of a line |
| out_eol | output | 1 | Last pixel of a line |
| out_col | output | 8 | Column index |
| out_band | output | 2 | Spectral band |
| out_pix | output | 16 | Corrected pixel, 8 fractional bits |

## Verification
The first line after reset runs with the default tables, so a wrong reset value shows up as output different from raw × 256. Lines whose offsets exceed some raw values, and whose gains push some products past full scale, separate the clamp path and the saturation path from plain scaling. The same raw pattern is sent in two bands to show that the band selects the entry. Bad-pixel lines cover three cases: flags at both line ends, flags on the first line of a band, and flags at the same column on consecutive lines. These tell apart a broken edge substitution, a broken no-history rule and the storing of uncorrected values. A write made in the middle of a line, followed by a line with no idle gap, checks when the staged coefficients take effect.

// File: rtl/calib_pkg.sv
package calib_pkg;

    localparam int PIX_W     = 8;
    localparam int GAIN_W    = 16;
    localparam int GAIN_FRAC = 8;
    localparam int OUT_W     = 16;
    localparam int COL_W     = 8;
    localparam int BAND_W    = 2;
    localparam int PROD_W    = PIX_W + GAIN_W;

    typedef struct packed {
        logic [PIX_W-1:0]  bias;
        logic [GAIN_W-1:0] gain;
        logic              defect;
    } cal_entry_t;

    typedef struct packed {
        logic              valid;
        logic              sol;
        logic              eol;
        logic [COL_W-1:0]  col;
        logic [BAND_W-1:0] band;
    } pix_tag_t;

    localparam cal_entry_t ENTRY_RESET = '{bias: '0, gain: GAIN_W'(1 << GAIN_FRAC), defect: 1'b0};

    function automatic logic [OUT_W-1:0] med3(input logic [OUT_W-1:0] a,
                                              input logic [OUT_W-1:0] b,
                                              input logic [OUT_W-1:0] c);
        logic [OUT_W-1:0] lo, hi;
        lo = (a < b) ? a : b;
        hi = (a < b) ? b : a;
        if (c < lo)      return lo;
        else if (c > hi) return hi;
        else             return c;
    endfunction

endpackage

// File: rtl/calib_table.sv
module calib_table
    import calib_pkg::*;
#(
    parameter int COLS  = 8,
    parameter int BANDS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  pix_tag_t          tag_in,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic              wr_en,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [BAND_W-1:0] wr_band,
    input  cal_entry_t        wr_entry,
    output pix_tag_t          tag_q,
    output logic [PIX_W-1:0]  pix_q,
    output cal_entry_t        ent_q
);
    localparam int NENT  = COLS * BANDS;
    localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1;

    cal_entry_t [NENT-1:0] stage_q;
    cal_entry_t [NENT-1:0] work_q;

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic             rd_ok, wr_ok;
    cal_entry_t       rd_ent;

    always_comb begin
        rd_idx = IDX_W'(int'(tag_in.band) * COLS + int'(tag_in.col));
        wr_idx = IDX_W'(int'(wr_band) * COLS + int'(wr_col));
        rd_ok  = (int'(tag_in.col) < COLS) && (int'(tag_in.band) < BANDS);
        wr_ok  = (int'(wr_col) < COLS) && (int'(wr_band) < BANDS);
        if (!rd_ok)          rd_ent = ENTRY_RESET;
        else if (tag_in.sol) rd_ent = stage_q[rd_idx];
        else                 rd_ent = work_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NENT; i++) begin
                stage_q[i] <= ENTRY_RESET;
                work_q[i]  <= ENTRY_RESET;
            end
            tag_q <= '0;
            pix_q <= '0;
            ent_q <= ENTRY_RESET;
        end else begin
            if (wr_en && wr_ok)
                stage_q[wr_idx] <= wr_entry;
            if (tag_in.valid && tag_in.sol)
                work_q <= stage_q;
            tag_q <= tag_in;
            pix_q <= pix_in;
            ent_q <= rd_ent;
        end
    end

    AST_WORK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(tag_in.valid && tag_in.sol) |=> $stable(work_q)) else $error("working table changed inside a line"); // R9

endmodule

// File: rtl/calib_correct.sv
module calib_correct
    import calib_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pix_tag_t         tag_in,
    input  logic [PIX_W-1:0] pix_in,
    input  cal_entry_t       ent_in,
    output pix_tag_t         tag_q,
    output logic [OUT_W-1:0] corr_q,
    output logic             bad_q
);
    localparam logic [OUT_W-1:0]  OUT_MAX  = {OUT_W{1'b1}};
    localparam logic [PROD_W-1:0] PROD_LIM = PROD_W'(OUT_MAX);

    logic [PIX_W-1:0]  diff;
    logic [PROD_W-1:0] prod;
    logic [OUT_W-1:0]  corr;

    always_comb begin
        diff = (pix_in >= ent_in.bias) ? (pix_in - ent_in.bias) : '0;
        prod = {{GAIN_W{1'b0}}, diff} * {{PIX_W{1'b0}}, ent_in.gain};
        corr = (prod > PROD_LIM) ? OUT_MAX : prod[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= '0;
            corr_q <= '0;
            bad_q  <= 1'b0;
        end else begin
            tag_q  <= tag_in;
            corr_q <= corr;
            bad_q  <= ent_in.defect;
        end
    end

    AST_CLAMP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tag_in.valid && (pix_in < ent_in.bias)) |=> (corr_q == '0)) else $error("negative difference not clamped"); // R2

    AST_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
        (tag_in.valid && (&pix_in) && (ent_in.bias == '0) && (&ent_in.gain)) |=> (corr_q == OUT_MAX)) else $error("overflow not saturated"); // R4

endmodule

// File: rtl/calib_defect.sv
module calib_defect
    import calib_pkg::*;
#(
    parameter int COLS  = 8,
    parameter int BANDS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  pix_tag_t         tag_in,
    input  logic [OUT_W-1:0] corr_in,
    input  logic             bad_in,
    output pix_tag_t         tag_q,
    output logic [OUT_W-1:0] pix_q
);
    localparam int NENT  = COLS * BANDS;
    localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1;
    localparam int NSEEN = 2 ** BAND_W;

    // centre of the three-pixel window
    pix_tag_t         tag_c;
    logic [OUT_W-1:0] corr_c;
    logic             bad_c;
    // older neighbour, also the output stage
    logic [OUT_W-1:0] corr_l;

    logic [NENT-1:0][OUT_W-1:0] prev_line;
    logic [NSEEN-1:0]           band_done;

    logic [IDX_W-1:0] idx_c;
    logic             idx_ok;
    logic [OUT_W-1:0] left_v, right_v, up_v, final_v;

    always_comb begin
        idx_c   = IDX_W'(int'(tag_c.band) * COLS + int'(tag_c.col));
        idx_ok  = (int'(tag_c.col) < COLS) && (int'(tag_c.band) < BANDS);
        left_v  = tag_c.sol ? corr_in : corr_l;
        right_v = tag_c.eol ? corr_l  : corr_in;
        up_v    = (band_done[tag_c.band] && idx_ok) ? prev_line[idx_c] : left_v;
        final_v = bad_c ? med3(left_v, right_v, up_v) : corr_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_c     <= '0;
            corr_c    <= '0;
            bad_c     <= 1'b0;
            tag_q     <= '0;
            corr_l    <= '0;
            pix_q     <= '0;
            prev_line <= '0;
            band_done <= '0;
        end else begin
            tag_c  <= tag_in;
            corr_c <= corr_in;
            bad_c  <= bad_in;
            tag_q  <= tag_c;
            corr_l <= corr_c;
            pix_q  <= final_v;
            if (tag_c.valid && idx_ok)
                prev_line[idx_c] <= final_v;
            if (tag_c.valid && tag_c.eol)
                band_done[tag_c.band] <= 1'b1;
        end
    end

    AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
        (tag_c.valid && !bad_c) |=> (pix_q == $past(corr_c))) else $error("unflagged pixel altered"); // R6

    AST_MEDIAN_SRC: assert property (@(posedge clk) disable iff (rst)
        (tag_c.valid && bad_c && tag_c.sol && !band_done[tag_c.band]) |=> (pix_q == $past(corr_in))) else $error("first-line start substitution wrong"); // R8

endmodule

// File: rtl/calib_pipe.sv
module calib_pipe
    import calib_pkg::*;
#(
    parameter int COLS  = 8,
    parameter int BANDS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sol,
    input  logic              in_eol,
    input  logic [COL_W-1:0]  in_col,
    input  logic [BAND_W-1:0] in_band,
    input  logic [PIX_W-1:0]  in_pix,
    input  logic              wr_en,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [BAND_W-1:0] wr_band,
    input  logic [PIX_W-1:0]  wr_bias,
    input  logic [GAIN_W-1:0] wr_gain,
    input  logic              wr_defect,
    output logic              out_valid,
    output logic              out_sol,
    output logic              out_eol,
    output logic [COL_W-1:0]  out_col,
    output logic [BAND_W-1:0] out_band,
    output logic [OUT_W-1:0]  out_pix
);
    pix_tag_t         tag_in, tag_a, tag_b, tag_o;
    logic [PIX_W-1:0] pix_a;
    cal_entry_t       ent_a, wr_entry;
    logic [OUT_W-1:0] corr_b;
    logic             bad_b;

    always_comb begin
        tag_in   = '{valid: in_valid, sol: in_valid & in_sol, eol: in_valid & in_eol,
                     col: in_col, band: in_band};
        wr_entry = '{bias: wr_bias, gain: wr_gain, defect: wr_defect};
    end

    calib_table #(.COLS(COLS), .BANDS(BANDS)) u_table (
        .clk(clk), .rst(rst), .tag_in(tag_in), .pix_in(in_pix),
        .wr_en(wr_en), .wr_col(wr_col), .wr_band(wr_band), .wr_entry(wr_entry),
        .tag_q(tag_a), .pix_q(pix_a), .ent_q(ent_a)
    );

    calib_correct u_correct (
        .clk(clk), .rst(rst), .tag_in(tag_a), .pix_in(pix_a), .ent_in(ent_a),
        .tag_q(tag_b), .corr_q(corr_b), .bad_q(bad_b)
    );

    calib_defect #(.COLS(COLS), .BANDS(BANDS)) u_defect (
        .clk(clk), .rst(rst), .tag_in(tag_b), .corr_in(corr_b), .bad_in(bad_b),
        .tag_q(tag_o), .pix_q(out_pix)
    );

    always_comb begin
        out_valid = tag_o.valid;
        out_sol   = tag_o.sol;
        out_eol   = tag_o.eol;
        out_col   = tag_o.col;
        out_band  = tag_o.band;
    end

    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4))) else $error("latency broken"); // R1

    AST_TAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        (out_sol || out_eol) |-> out_valid) else $error("line tag without valid"); // R1

endmodule

// File: tb/sim_calib_pipe.sv
module sim_calib_pipe;
    localparam int COLS  = 8;
    localparam int BANDS = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
    logic [7:0]  in_col = '0;
    logic [1:0]  in_band = '0;
    logic [7:0]  in_pix = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_col = '0;
    logic [1:0]  wr_band = '0;
    logic [7:0]  wr_bias = '0;
    logic [15:0] wr_gain = '0;
    logic        wr_defect = 1'b0;
    logic        out_valid, out_sol, out_eol;
    logic [7:0]  out_col;
    logic [1:0]  out_band;
    logic [15:0] out_pix;

    always #2 clk = ~clk;

    calib_pipe #(.COLS(COLS), .BANDS(BANDS)) u0 (.*);

    typedef struct {
        int    pix;
        int    col;
        int    band;
        bit    sol;
        bit    eol;
        longint cyc;
        string tag;
    } exp_t;

    exp_t   sb[$];
    int     checks = 0;
    int     fails  = 0;
    longint cyc    = 0;
    bit     done   = 1'b0;

    // bench model of the requirements
    int m_bias [BANDS][COLS];
    int m_gain [BANDS][COLS];
    bit m_def  [BANDS][COLS];
    int m_line [BANDS][COLS];
    bit m_seen [BANDS];
    int line_raw [COLS];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int mid3(int a, int b, int c);
        int t;
        if (a > b) begin t = a; a = b; b = t; end
        if (b > c) begin t = b; b = c; c = t; end
        if (a > b) begin t = a; a = b; b = t; end
        return b;
    endfunction

    task automatic host_write(int b, int c, int bias, int gain, bit def);
        in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
        wr_en = 1'b1; wr_band = 2'(b); wr_col = 8'(c);
        wr_bias = 8'(bias); wr_gain = 16'(gain); wr_defect = def;
        m_bias[b][c] = bias; m_gain[b][c] = gain; m_def[b][c] = def;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // called at a falling edge; leaves the bench at a falling edge
    task automatic drive_line(int b, string ovr, bit wr_mid, int wcol, int tcol,
                              int wbias, int wgain, bit wdef, bit gap);
        int corr [COLS];
        int outv [COLS];
        for (int c = 0; c < COLS; c++) begin
            int d, p;
            d = (line_raw[c] > m_bias[b][c]) ? line_raw[c] - m_bias[b][c] : 0;
            p = d * m_gain[b][c];
            corr[c] = (p > 65535) ? 65535 : p;
        end
        for (int c = 0; c < COLS; c++) begin
            exp_t e;
            int l, r, u;
            string t;
            l = (c == 0) ? corr[1] : corr[c-1];
            r = (c == COLS-1) ? corr[c-1] : corr[c+1];
            u = m_seen[b] ? m_line[b][c] : l;
            if (m_def[b][c]) begin
                outv[c] = mid3(l, r, u);
                if (!m_seen[b])                   t = "R8";
                else if (c == 0 || c == COLS-1)   t = "R7";
                else                              t = "R6";
            end else begin
                outv[c] = corr[c];
                if (corr[c] == 65535)                       t = "R4";
                else if (line_raw[c] <= m_bias[b][c])       t = "R2";
                else                                         t = "R3";
            end
            if (ovr != "") t = ovr;
            e.pix = outv[c]; e.col = c; e.band = b;
            e.sol = (c == 0); e.eol = (c == COLS-1);
            e.cyc = cyc + c + 4; e.tag = t;
            sb.push_back(e);
        end
        for (int c = 0; c < COLS; c++) m_line[b][c] = outv[c];
        m_seen[b] = 1'b1;
        for (int c = 0; c < COLS; c++) begin
            in_valid = 1'b1; in_sol = (c == 0); in_eol = (c == COLS-1);
            in_col = 8'(c); in_band = 2'(b); in_pix = 8'(line_raw[c]);
            if (wr_mid && c == wcol) begin
                wr_en = 1'b1; wr_band = 2'(b); wr_col = 8'(tcol);
                wr_bias = 8'(wbias); wr_gain = 16'(wgain); wr_defect = wdef;
                m_bias[b][tcol] = wbias; m_gain[b][tcol] = wgain; m_def[b][tcol] = wdef;
            end
            @(negedge clk);
            wr_en = 1'b0;
        end
        if (gap) begin
            in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
            @(negedge clk);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R1: unexpected output pix=%0h col=%0d", out_pix, out_col);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (out_pix !== 16'(e.pix) || out_col !== 8'(e.col) || out_band !== 2'(e.band) ||
                    out_sol !== e.sol || out_eol !== e.eol || cyc != e.cyc) begin
                    fails++;
                    $display("FAIL %s: pix=%0h col=%0d band=%0d sol=%0b eol=%0b cyc=%0d expected pix=%0h col=%0d band=%0d sol=%0b eol=%0b cyc=%0d",
                             e.tag, out_pix, out_col, out_band, out_sol, out_eol, cyc,
                             e.pix, e.col, e.band, e.sol, e.eol, e.cyc);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < BANDS; b++) begin
            m_seen[b] = 1'b0;
            for (int c = 0; c < COLS; c++) begin
                m_bias[b][c] = 0; m_gain[b][c] = 256; m_def[b][c] = 1'b0; m_line[b][c] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state of the output
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R10: out_valid=%0b expected 0", out_valid);
        end

        // R10: default tables give raw*256
        for (int c = 0; c < COLS; c++) line_raw[c] = (c * 37 + 5) % 256;
        drive_line(0, "R10", 0, 0, 0, 0, 0, 0, 1);

        // R2 / R3 / R4: offsets, gains, clamp and saturation on band 0
        for (int c = 0; c < COLS; c++) host_write(0, c, c * 10, 256 + c * 32, 0);
        host_write(0, 2, 200, 300, 0);
        host_write(0, 6, 0, 65535, 0);
        for (int c = 0; c < COLS; c++) line_raw[c] = (c * 53 + 40) % 256;
        drive_line(0, "", 0, 0, 0, 0, 0, 0, 1);

        // R8: band 1 bad pixels before it has completed any line
        for (int c = 0; c < COLS; c++) host_write(1, c, 3, 128, (c == 2) || (c == 0));
        drive_line(1, "", 0, 0, 0, 0, 0, 0, 1);

        // R5: same raw pattern in band 1 corrected by band-1 entries
        drive_line(1, "R5", 0, 0, 0, 0, 0, 0, 1);

        // R6 / R7: bad pixels at both ends and in the middle of band 0
        host_write(0, 0, 0, 256, 1);
        host_write(0, 4, 10, 400, 1);
        host_write(0, 7, 0, 256, 1);
        for (int c = 0; c < COLS; c++) line_raw[c] = (c * 91 + 17) % 256;
        drive_line(0, "", 0, 0, 0, 0, 0, 0, 1);

        // R11: same flags again, previous-line values are replaced outputs
        for (int c = 0; c < COLS; c++) line_raw[c] = (c * 29 + 200) % 256;
        drive_line(0, "R11", 0, 0, 0, 0, 0, 0, 1);

        // R9: write in the middle of a line, next line follows without a gap
        for (int c = 0; c < COLS; c++) line_raw[c] = (c * 13 + 60) % 256;
        drive_line(0, "R9", 1, 3, 5, 0, 512, 0, 0);
        drive_line(0, "R9", 1, 0, 1, 50, 1024, 0, 1);
        drive_line(0, "R9", 0, 0, 0, 0, 0, 0, 1);

        // R3: plain band-1 line after the others
        for (int c = 0; c < COLS; c++) line_raw[c] = (c * 7 + 100) % 256;
        drive_line(1, "", 0, 0, 0, 0, 0, 0, 1);

        repeat (10) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R1: %0d outputs missing, expected 0", sb.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule